// File: doc/BRIEF.md
# Word-Clock Ratio Detector and Lock Monitor

This block runs on the converter's system clock and watches the incoming word (frame) clock. It counts system clocks between rising word-clock edges and decides whether the system clock runs at 256, 384 or 512 times the sample rate. From that decision it produces a clock enable that pulses exactly 256 times per frame, whatever the ratio. Downstream filter and modulator timing runs from this enable.

It also tracks whether the frame timing stays locked to the system clock. A phase jump of the word-clock edge well beyond a few bit-clock periods drops the lock and raises a mute that forces bipolar-zero output until two consistent frames are seen again. A power-good input drives a power-on reset sequence: the internal reset is held for a fixed number of system clocks, and the mute then stays up for a fixed number of frames while the filters settle.

The phase-shift threshold is counted in bit-clock periods. One bit-clock period is one sixty-fourth of a frame, so in system clocks it is 4, 6 or 8 at the three ratios.

Top module: `clk_ratio_sync`

## Requirements
- R1: `rst_int` is high while `pwr_ok` is low and for exactly `POR_CYCLES` rising clock edges after `pwr_ok` goes high; it then stays low while `pwr_ok` stays high.
- R2: At each rising word-clock edge after the first, `ratio` takes the code for the length of the frame just ended: 1 for 256, 2 for 384, 3 for 512 system clocks, each within ±`SLIP_BCK` bit-clock periods; 0 for any other length. `ratio` changes only on a rising word-clock edge.
- R3: Lock is gained when a frame length matches the current nonzero `ratio` code. `mute` can only fall on the cycle after a rising word-clock edge.
- R4: `en256` pulses exactly 256 times per frame at every ratio: on every clock at code 1, on two of every three clocks at code 2, and on every other clock at code 3, with the pattern restarting at each rising word-clock edge.
- R5: `en256` stays low while `rst_int` is high or `ratio` is 0.
- R6: A frame-length change of 4 bit-clock periods or less, measured from the previous frame, keeps the lock, and `mute` stays low.
- R7: A frame whose length is off nominal by more than `SLIP_BCK` bit-clock periods, or differs from the previous frame by more than that, drops the lock. `mute` rises on the next clock, and a relock needs one more matching frame.
- R8: After `rst_int` falls, `mute` stays high until `SETTLE_FRAMES` rising word-clock edges have been seen, even if lock is already held.
- R9: Dropping `pwr_ok` asserts `rst_int` and `mute` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_ok | input | 1 | Power good, low resets the block asynchronously |
| lrck | input | 1 | Word clock, synchronous to `clk` |
| ratio | output | 2 | Detected ratio code: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| en256 | output | 1 | Clock enable at 256 times the sample rate |
| rst_int | output | 1 | Internal reset for downstream logic |
| mute | output | 1 | Force bipolar-zero output |

## Verification
The bench plays a sequence of frames and checks a phase nudge that must be tolerated (12 clocks at ratio 256) against jumps that must not be: an out-of-window 282-clock frame, and a +32/−32 pair at ratio 512 that stays in the window but jumps 64 clocks between frames. A design that compared only against nominal would miss the pair. A design with too tight a window would mute on the nudge. Enable pulses are counted over whole frames at each ratio, so a 384 divider that slips phase at the frame edge shows up as 255 or 257. The settle window is checked while lock is already held, which separates a mute tied only to lock from one that also honours the post-reset delay.

// File: rtl/clk_ratio_sync.sv
module clk_ratio_sync #(
  parameter int POR_CYCLES    = 1024,
  parameter int SETTLE_FRAMES = 18436,
  parameter int BCK_PER_FRAME = 64,
  parameter int SLIP_BCK      = 5,
  parameter int CNT_W         = 11
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       lrck,
  output logic [1:0] ratio,
  output logic       en256,
  output logic       rst_int,
  output logic       mute
);

  localparam int POR_W = $clog2(POR_CYCLES + 1);
  localparam int SET_W = $clog2(SETTLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] NOM1 = CNT_W'(256);
  localparam logic [CNT_W-1:0] NOM2 = CNT_W'(384);
  localparam logic [CNT_W-1:0] NOM3 = CNT_W'(512);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(SLIP_BCK * 256 / BCK_PER_FRAME);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(SLIP_BCK * 384 / BCK_PER_FRAME);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(SLIP_BCK * 512 / BCK_PER_FRAME);
  localparam logic [POR_W-1:0] POR_END = POR_W'(POR_CYCLES);
  localparam logic [SET_W-1:0] SET_END = SET_W'(SETTLE_FRAMES);

  logic [POR_W-1:0] por_cnt;
  logic [SET_W-1:0] settle;
  logic [CNT_W-1:0] cnt, prev;
  logic [CNT_W-1:0] lim;
  logic [1:0]       cls, div, div_nx;
  logic             lr_q, armed, locked, slip;
  logic             lr_rise;

  function automatic logic [CNT_W-1:0] adiff(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  assign rst_int = (por_cnt != POR_END);
  assign lr_rise = lrck & ~lr_q;

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok)     por_cnt <= '0;
    else if (rst_int) por_cnt <= por_cnt + 1'b1;

  always_comb begin
    cls = 2'd0;
    lim = '0;
    if (adiff(cnt, NOM1) <= LIM1)      begin cls = 2'd1; lim = LIM1; end
    else if (adiff(cnt, NOM2) <= LIM2) begin cls = 2'd2; lim = LIM2; end
    else if (adiff(cnt, NOM3) <= LIM3) begin cls = 2'd3; lim = LIM3; end
  end

  assign slip = adiff(cnt, prev) > lim;

  always_comb
    case (ratio)
      2'd2:    div_nx = (div == 2'd2) ? 2'd0 : div + 2'd1;
      2'd3:    div_nx = {1'b0, ~div[0]};
      default: div_nx = 2'd0;
    endcase

  always_ff @(posedge clk or negedge pwr_ok)
    if (!pwr_ok || rst_int) begin
      lr_q   <= 1'b0;
      cnt    <= '0;
      prev   <= '0;
      div    <= 2'd0;
      armed  <= 1'b0;
      ratio  <= 2'd0;
      locked <= 1'b0;
      settle <= '0;
    end else begin
      lr_q <= lrck;
      if (lr_rise) begin
        cnt   <= CNT_W'(1);
        div   <= 2'd0;
        prev  <= cnt;
        armed <= 1'b1;
        if (settle != SET_END) settle <= settle + 1'b1;
        if (armed) begin
          ratio  <= cls;
          locked <= (cls != 2'd0) && (cls == ratio) && !slip;
        end
      end else begin
        cnt <= (&cnt) ? cnt : cnt + 1'b1;
        div <= div_nx;
      end
    end

  assign en256 = !rst_int && ((ratio == 2'd1) ||
                              (ratio == 2'd2 && div != 2'd2) ||
                              (ratio == 2'd3 && div == 2'd0));

  assign mute = rst_int || !locked || (settle != SET_END);

  AST_POR_STAYS_LOW: assert property (@(posedge clk) disable iff (!pwr_ok) !rst_int |=> !rst_int); // R1
  AST_RATIO_ON_EDGE: assert property (@(posedge clk) disable iff (!pwr_ok || rst_int) !lr_rise |=> $stable(ratio)); // R2
  AST_UNMUTE_ON_EDGE: assert property (@(posedge clk) disable iff (!pwr_ok) $fell(mute) |-> $past(lr_rise)); // R3
  AST_LOCK_HAS_RATIO: assert property (@(posedge clk) disable iff (!pwr_ok) locked |-> ratio != 2'd0); // R3
  AST_HALF_RATE_GAP: assert property (@(posedge clk) disable iff (!pwr_ok || rst_int)
    (ratio == 2'd3 && en256 && !lr_rise) |=> !en256); // R4

endmodule

// File: tb/tb_clk_ratio_sync.sv
module tb_clk_ratio_sync;
  localparam int CLK_P  = 10;
  localparam int POR    = 20;
  localparam int SETTLE = 5;
  localparam int NV     = 25;
  localparam int LEN  [NV] = '{256,256,256,268,256,256,282,256,256,256,384,384,384,384,512,512,512,300,512,512,512,544,480,512,512};
  localparam int EXR  [NV] = '{0,1,1,1,1,1,1,0,1,1,1,2,2,2,2,3,3,3,0,3,3,3,3,3,3};
  localparam int EXM  [NV] = '{1,1,1,1,0,0,0,1,1,0,0,1,0,0,0,1,0,0,1,1,0,0,0,1,0};
  localparam int EXEN [NV] = '{0,-1,-1,-1,-1,256,-1,-1,-1,256,-1,-1,-1,256,-1,-1,-1,-1,-1,-1,256,-1,-1,-1,-1};

  logic clk = 0, pwr_ok = 0, lrck = 0;
  logic [1:0] ratio;
  logic en256, rst_int, mute;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  clk_ratio_sync #(.POR_CYCLES(POR), .SETTLE_FRAMES(SETTLE)) dut (
    .clk(clk), .pwr_ok(pwr_ok), .lrck(lrck),
    .ratio(ratio), .en256(en256), .rst_int(rst_int), .mute(mute));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int len, output int ens);
    ens = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (en256) ens++;
      lrck = (i < len / 2);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    end
    $finish;
  end

  initial begin
    int ens;
    repeat (5) @(negedge clk);
    check("R1 rst_int in reset", int'(rst_int), 1);
    check("R9 mute in reset", int'(mute), 1);
    check("R5 en256 in reset", int'(en256), 0);
    check("R2 ratio in reset", int'(ratio), 0);
    pwr_ok = 1;
    repeat (POR - 1) @(negedge clk);
    check("R1 rst_int before count ends", int'(rst_int), 1);
    @(negedge clk);
    check("R1 rst_int released", int'(rst_int), 0);
    check("R8 mute after release", int'(mute), 1);
    repeat (3) @(negedge clk);
    check("R5 en256 no ratio yet", int'(en256), 0);

    for (int v = 0; v < NV; v++) begin
      frame(LEN[v], ens);
      // R2 R3 R6 R7 R8 per frame row
      check($sformatf("R2 ratio frame %0d", v), int'(ratio), EXR[v]);
      check($sformatf("R3/R6/R7/R8 mute frame %0d", v), int'(mute), EXM[v]);
      if (EXEN[v] >= 0) check($sformatf("R4/R5 en256 count frame %0d", v), ens, EXEN[v]);
    end

    @(negedge clk);
    pwr_ok = 0;
    #1;
    check("R9 rst_int on power drop", int'(rst_int), 1);
    check("R9 mute on power drop", int'(mute), 1);
    #(CLK_P);
    check("R5 en256 after power drop", int'(en256), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule